// File: doc/BRIEF.md
# Integer Load/Store-Multiple Micro-Op Sequencer

This block sits in an instruction decoder and turns one register-list load-multiple or store-multiple instruction into an ordered stream of micro-ops. The instruction arrives as a 16-bit register list, a 4-bit base register index and five flags: ascending/descending, pre-index, user, writeback and load/store. The micro-ops leave one per valid/ready handshake. Each one carries an opcode, a data/destination register index, a source/address register index, a byte offset, an address direction bit and four flags: last, delayed-commit, control and return.

Every sequence starts by copying the base register into a temporary, and all memory micro-ops address relative to that temporary. For a load with writeback, the highest listed register is loaded into a second temporary. The base update follows, and the temporary is then moved into its real target, so no memory fault can happen after the base has changed. The user flag picks one of two forms. When the list leaves out register 15, the transfers name user-bank registers. When the list includes register 15, the program-counter load becomes an exception-return load.

Register index encoding on the outputs (6 bits): 0..15 are the current-mode registers, 16+r is the user-bank view of register r, 32 is temporary 0 and 33 is temporary 1. Opcode encoding (3 bits): 0 add-immediate, 1 subtract-immediate, 2 load, 3 exception-return load, 4 store, 5 register move, 6 exception-return move.

Top module: `lsm_uop_seq`

## Requirements
- R1: `in_ready` is 1 and `busy` is 0 exactly when no sequence is in progress. An instruction is accepted only on a cycle with `in_valid` and `in_ready` both 1, and `in_valid` while busy is ignored.
- R2: With n set bits in the list, the sequence has n+1 micro-ops, plus 2 for a load with writeback or plus 1 for a store with writeback. An empty list gives exactly 1 micro-op, whatever the flags are.
- R3: The first micro-op of every sequence is add-immediate (0) with destination 32, source equal to the base index and offset 0.
- R4: Memory micro-ops have source 32 and `out_ascend` equal to the ascending flag. The first offset is 0 when ascending and 4n-4 when descending, plus 4 when pre-index is 0. Non-memory micro-ops have `out_ascend` 0.
- R5: Memory micro-ops visit the listed registers from the lowest index to the highest, and the offset changes by +4 (ascending) or -4 (descending) per register. The opcode is store (4) for a store and load (2) for a load.
- R6: For a load with writeback and n>0, the highest listed register is loaded into 33. Next comes the base update: add-immediate (ascending) or subtract-immediate (descending), with destination and source equal to the base and offset 4n. Last comes a move (5) from 33 into the target with offset 0. A store with writeback ends with the base update.
- R7: User flag 1 with list bit 15 at 0 makes every transferred register index appear as 16+r, including the target of the final move.
- R8: User flag 1 with list bit 15 at 1 makes the direct load of register 15 an exception-return load (3). When register 15 is staged through 33, the final move becomes an exception-return move (6) with destination 15.
- R9: `out_ctrl` is 1 only on a plain move (5) whose target is 15. `out_ret` is 1 only when `out_ctrl` is 1 and the base is 13.
- R10: The final micro-op has `out_last` 1 and `out_delay` 0. Every earlier micro-op has `out_last` 0 and `out_delay` 1. No micro-op is offered in the cycle after the last one is taken.
- R11: While `out_valid` is 1 and `out_ready` is 0, every micro-op output holds its value.
- R12: After reset `out_valid` is 0, `in_ready` is 1 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction taken this cycle if valid |
| in_list | input | 16 | Register list, bit r selects register r |
| in_base | input | 4 | Base register index |
| in_ascend | input | 1 | 1 ascending addresses, 0 descending |
| in_pre | input | 1 | 1 pre-index, 0 adds 4 to the first offset |
| in_user | input | 1 | User-bank / exception-return selector |
| in_wb | input | 1 | Write the updated base back |
| in_load | input | 1 | 1 load, 0 store |
| out_valid | output | 1 | Micro-op offered |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_op | output | 3 | Opcode |
| out_dst | output | 6 | Data or destination register index |
| out_src | output | 6 | Source or address register index |
| out_off | output | 8 | Byte offset or immediate |
| out_ascend | output | 1 | Address direction of a memory micro-op |
| out_last | output | 1 | Final micro-op of the sequence |
| out_delay | output | 1 | Commit held until the sequence completes |
| out_ctrl | output | 1 | Indirect conditional control transfer |
| out_ret | output | 1 | Control transfer is a return |
| busy | output | 1 | Sequence in progress |

## Verification
The main function is exercised with ten instruction patterns. Empty lists with and without writeback show the single-micro-op rule. Ascending and descending lists, with pre-index both set and clear, separate the four offset starting points. Loads with writeback whose last register is 15, with the base at 13 and elsewhere, separate the return and non-return control marks. User-flag cases with and without bit 15 separate user-bank indexing from the exception-return forms. A full 16-register load reaches the largest offset and sequence length. Directed runs cover the reset state, a stalled consumer, and a second request raised while the block is busy.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    parameter int NREG  = 16;
    parameter int IDX_W = $clog2(NREG);
    parameter int RID_W = IDX_W + 2;
    parameter int OFF_W = IDX_W + 4;
    parameter int CNT_W = IDX_W + 1;

    parameter logic [IDX_W-1:0] PC_IDX = IDX_W'(NREG - 1);
    parameter logic [IDX_W-1:0] SP_IDX = IDX_W'(NREG - 3);
    parameter logic [RID_W-1:0] TMP0   = RID_W'(2 * NREG);
    parameter logic [RID_W-1:0] TMP1   = RID_W'(2 * NREG + 1);

    typedef enum logic [2:0] {
        OP_ADDI    = 3'd0,
        OP_SUBI    = 3'd1,
        OP_LOAD    = 3'd2,
        OP_LOADRET = 3'd3,
        OP_STORE   = 3'd4,
        OP_MOV     = 3'd5,
        OP_MOVRET  = 3'd6
    } uop_op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_COPY,
        PH_MEM,
        PH_BASE,
        PH_MOVE
    } phase_e;

    typedef struct packed {
        logic [IDX_W-1:0] base;
        logic             ascend;
        logic             load;
        logic             wb;
        logic             force_user;
        logic             exc_ret;
        logic [CNT_W-1:0] n;
    } ctx_t;

    typedef struct packed {
        uop_op_e          op;
        logic [RID_W-1:0] dst;
        logic [RID_W-1:0] src;
        logic [OFF_W-1:0] off;
        logic             ascend;
        logic             last;
        logic             delay;
        logic             ctrl;
        logic             ret;
    } uop_t;

    function automatic logic [CNT_W-1:0] popcnt(input logic [NREG-1:0] m);
        logic [CNT_W-1:0] c;
        c = '0;
        for (int i = 0; i < NREG; i++) begin
            c = c + CNT_W'(m[i]);
        end
        return c;
    endfunction

    function automatic logic [OFF_W-1:0] start_offset(input logic [CNT_W-1:0] n,
                                                      input logic ascend,
                                                      input logic pre);
        logic [OFF_W-1:0] s;
        s = ascend ? '0 : ((OFF_W'(n) << 2) - OFF_W'(4));
        if (!pre) begin
            s = s + OFF_W'(4);
        end
        return s;
    endfunction
endpackage

// File: rtl/lsm_prio_pick.sv
module lsm_prio_pick
    import lsm_pkg::*;
#(
    parameter int W = NREG,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic          only_one,
    output logic [W-1:0]  rest
);
    logic [W-1:0] minus_one;

    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx = IW'(i);
            end
        end
    end

    assign minus_one = mask - W'(1);
    assign rest      = mask & minus_one;
    assign only_one  = (mask != '0) && (rest == '0);
endmodule

// File: rtl/lsm_bank_map.sv
module lsm_bank_map
    import lsm_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic             force_user,
    output logic [RID_W-1:0] rid
);
    assign rid = force_user ? {2'b01, idx} : {2'b00, idx};
endmodule

// File: rtl/lsm_uop_form.sv
module lsm_uop_form
    import lsm_pkg::*;
(
    input  phase_e           phase,
    input  ctx_t             ctx,
    input  logic [OFF_W-1:0] off,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic             pick_only,
    input  logic [RID_W-1:0] pick_rid,
    input  logic [IDX_W-1:0] last_idx,
    input  logic [RID_W-1:0] last_rid,
    output uop_t             uop
);
    logic staged;
    logic retmove;

    assign staged  = ctx.load && ctx.wb && pick_only;
    assign retmove = ctx.exc_ret && (last_idx == PC_IDX);

    always_comb begin
        uop = '0;
        uop.op = OP_ADDI;
        unique case (phase)
            PH_COPY: begin
                uop.op   = OP_ADDI;
                uop.dst  = TMP0;
                uop.src  = RID_W'(ctx.base);
                uop.off  = '0;
                uop.last = (ctx.n == '0);
            end
            PH_MEM: begin
                if (ctx.load) begin
                    uop.op  = (!staged && ctx.exc_ret && pick_idx == PC_IDX) ? OP_LOADRET : OP_LOAD;
                    uop.dst = staged ? TMP1 : pick_rid;
                end else begin
                    uop.op  = OP_STORE;
                    uop.dst = pick_rid;
                end
                uop.src    = TMP0;
                uop.off    = off;
                uop.ascend = ctx.ascend;
                uop.last   = pick_only && !ctx.wb;
            end
            PH_BASE: begin
                uop.op   = ctx.ascend ? OP_ADDI : OP_SUBI;
                uop.dst  = RID_W'(ctx.base);
                uop.src  = RID_W'(ctx.base);
                uop.off  = OFF_W'(ctx.n) << 2;
                uop.last = !ctx.load;
            end
            PH_MOVE: begin
                uop.op   = retmove ? OP_MOVRET : OP_MOV;
                uop.dst  = retmove ? RID_W'(PC_IDX) : last_rid;
                uop.src  = TMP1;
                uop.ctrl = !retmove && (last_idx == PC_IDX);
                uop.ret  = !retmove && (last_idx == PC_IDX) && (ctx.base == SP_IDX);
                uop.last = 1'b1;
            end
            default: uop = '0;
        endcase
        uop.delay = (phase != PH_IDLE) && !uop.last;
    end
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
    import lsm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [NREG-1:0]  in_list,
    input  logic [IDX_W-1:0] in_base,
    input  logic             in_ascend,
    input  logic             in_pre,
    input  logic             in_user,
    input  logic             in_wb,
    input  logic             in_load,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [2:0]       out_op,
    output logic [RID_W-1:0] out_dst,
    output logic [RID_W-1:0] out_src,
    output logic [OFF_W-1:0] out_off,
    output logic             out_ascend,
    output logic             out_last,
    output logic             out_delay,
    output logic             out_ctrl,
    output logic             out_ret,
    output logic             busy
);
    phase_e           phase_q;
    ctx_t             ctx_q;
    logic [NREG-1:0]  mask_q;
    logic [OFF_W-1:0] off_q;
    logic [IDX_W-1:0] last_q;

    logic [IDX_W-1:0] pick_idx;
    logic             pick_only;
    logic [NREG-1:0]  pick_rest;
    logic [RID_W-1:0] pick_rid;
    logic [RID_W-1:0] last_rid;
    uop_t             uop;
    logic             accept;
    logic             fire;

    assign in_ready  = (phase_q == PH_IDLE);
    assign busy      = !in_ready;
    assign out_valid = (phase_q != PH_IDLE);
    assign accept    = in_valid && in_ready;
    assign fire      = out_valid && out_ready;

    lsm_prio_pick #(.W(NREG)) u_pick (
        .mask     (mask_q),
        .idx      (pick_idx),
        .only_one (pick_only),
        .rest     (pick_rest)
    );

    lsm_bank_map u_map_pick (
        .idx        (pick_idx),
        .force_user (ctx_q.force_user),
        .rid        (pick_rid)
    );

    lsm_bank_map u_map_last (
        .idx        (last_q),
        .force_user (ctx_q.force_user),
        .rid        (last_rid)
    );

    lsm_uop_form u_form (
        .phase     (phase_q),
        .ctx       (ctx_q),
        .off       (off_q),
        .pick_idx  (pick_idx),
        .pick_only (pick_only),
        .pick_rid  (pick_rid),
        .last_idx  (last_q),
        .last_rid  (last_rid),
        .uop       (uop)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            ctx_q   <= '0;
            mask_q  <= '0;
            off_q   <= '0;
            last_q  <= '0;
        end else if (accept) begin
            ctx_q.base       <= in_base;
            ctx_q.ascend     <= in_ascend;
            ctx_q.load       <= in_load;
            ctx_q.wb         <= in_wb;
            ctx_q.force_user <= in_user && !in_list[NREG-1];
            ctx_q.exc_ret    <= in_user && in_list[NREG-1];
            ctx_q.n          <= popcnt(in_list);
            mask_q           <= in_list;
            off_q            <= start_offset(popcnt(in_list), in_ascend, in_pre);
            phase_q          <= PH_COPY;
        end else if (fire) begin
            unique case (phase_q)
                PH_COPY: phase_q <= (ctx_q.n == '0) ? PH_IDLE : PH_MEM;
                PH_MEM: begin
                    mask_q <= pick_rest;
                    off_q  <= ctx_q.ascend ? off_q + OFF_W'(4) : off_q - OFF_W'(4);
                    last_q <= pick_idx;
                    if (pick_only) begin
                        phase_q <= ctx_q.wb ? PH_BASE : PH_IDLE;
                    end
                end
                PH_BASE: phase_q <= ctx_q.load ? PH_MOVE : PH_IDLE;
                PH_MOVE: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign out_op     = uop.op;
    assign out_dst    = uop.dst;
    assign out_src    = uop.src;
    assign out_off    = uop.off;
    assign out_ascend = uop.ascend;
    assign out_last   = uop.last;
    assign out_delay  = uop.delay;
    assign out_ctrl   = uop.ctrl;
    assign out_ret    = uop.ret;

    assert_copy_first_R3: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid && out_op == OP_ADDI && out_dst == TMP0
                   && out_src == RID_W'($past(in_base)) && out_off == '0);

    assert_hold_stall_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_op)
                   && $stable(out_dst) && $stable(out_src) && $stable(out_off));

    assert_end_after_last_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid);

    assert_one_reg_per_step_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_MEM && fire) |=> ($countones(mask_q) + 1 == $countones($past(mask_q))));

    assert_ctrl_on_pc_move_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ctrl) |-> (out_op == OP_MOV && out_dst == RID_W'(PC_IDX) && out_src == TMP1));

    assert_busy_blocks_R1: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy && !in_ready);
endmodule

// File: tb/tb_lsm_uop_seq.sv
module tb_lsm_uop_seq;
    localparam logic [2:0] K_ADDI = 3'd0, K_SUBI = 3'd1, K_LD = 3'd2, K_LDR = 3'd3,
                           K_ST = 3'd4, K_MOV = 3'd5, K_MOVR = 3'd6;
    localparam logic [5:0] T0 = 6'd32, T1 = 6'd33;

    typedef struct packed {
        logic [15:0] list;
        logic [3:0]  base;
        logic        asc;
        logic        pre;
        logic        user;
        logic        wb;
        logic        ld;
        logic [4:0]  cnt;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 4'd3,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1},
        '{16'h0000, 4'd4,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd1},
        '{16'h00F0, 4'd13, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 5'd6},
        '{16'h8011, 4'd13, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd6},
        '{16'h8003, 4'd1,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 5'd4},
        '{16'h8102, 4'd2,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 5'd6},
        '{16'h6100, 4'd0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd4},
        '{16'hFFFF, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 5'd19},
        '{16'h8000, 4'd5,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 5'd4},
        '{16'h0400, 4'd6,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 5'd4}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_ready;
    logic [15:0] in_list = '0;
    logic [3:0] in_base = '0;
    logic in_ascend = 1'b0, in_pre = 1'b0, in_user = 1'b0, in_wb = 1'b0, in_load = 1'b0;
    logic out_valid, out_ready = 1'b0;
    logic [2:0] out_op;
    logic [5:0] out_dst, out_src;
    logic [7:0] out_off;
    logic out_ascend, out_last, out_delay, out_ctrl, out_ret, busy;

    always #10 clk = ~clk;

    lsm_uop_seq dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_list(in_list), .in_base(in_base), .in_ascend(in_ascend), .in_pre(in_pre),
        .in_user(in_user), .in_wb(in_wb), .in_load(in_load),
        .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
        .out_dst(out_dst), .out_src(out_src), .out_off(out_off),
        .out_ascend(out_ascend), .out_last(out_last), .out_delay(out_delay),
        .out_ctrl(out_ctrl), .out_ret(out_ret), .busy(busy)
    );

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [2:0] e_op   [32];
    logic [5:0] e_dst  [32];
    logic [5:0] e_src  [32];
    logic [7:0] e_off  [32];
    logic       e_asc  [32];
    logic       e_ctrl [32];
    logic       e_ret  [32];
    string      e_tag  [32];
    int         e_n;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    task automatic push(input logic [2:0] op, input logic [5:0] d, input logic [5:0] s,
                        input logic [7:0] o, input logic a, input logic c,
                        input logic r, input string tag);
        e_op[e_n] = op; e_dst[e_n] = d; e_src[e_n] = s; e_off[e_n] = o;
        e_asc[e_n] = a; e_ctrl[e_n] = c; e_ret[e_n] = r; e_tag[e_n] = tag;
        e_n++;
    endtask

    // Reference sequence built from the requirements.
    task automatic build(input vec_t v);
        int n, seen, off, lastr;
        bit fu, er;
        logic [5:0] mr, bs;
        e_n = 0;
        n = $countones(v.list);
        fu = v.user && !v.list[15];
        er = v.user && v.list[15];
        bs = {2'b00, v.base};
        push(K_ADDI, T0, bs, 8'd0, 1'b0, 1'b0, 1'b0, "R3");
        off = v.asc ? 0 : n * 4 - 4;
        if (!v.pre) off += 4;
        seen = 0;
        lastr = 0;
        for (int r = 0; r < 16; r++) begin
            if (v.list[r]) begin
                seen++;
                mr = fu ? 6'(16 + r) : 6'(r);
                if (v.ld && v.wb && seen == n)
                    push(K_LD, T1, T0, 8'(off), v.asc, 1'b0, 1'b0, "R6");
                else if (v.ld && r == 15 && er)
                    push(K_LDR, 6'd15, T0, 8'(off), v.asc, 1'b0, 1'b0, "R8");
                else
                    push(v.ld ? K_LD : K_ST, mr, T0, 8'(off), v.asc, 1'b0, 1'b0, fu ? "R7" : "R5");
                off = v.asc ? off + 4 : off - 4;
                lastr = r;
            end
        end
        if (v.wb && n > 0) begin
            push(v.asc ? K_ADDI : K_SUBI, bs, bs, 8'(4 * n), 1'b0, 1'b0, 1'b0, "R6");
            if (v.ld) begin
                if (lastr == 15 && er)
                    push(K_MOVR, 6'd15, T1, 8'd0, 1'b0, 1'b0, 1'b0, "R8");
                else
                    push(K_MOV, fu ? 6'(16 + lastr) : 6'(lastr), T1, 8'd0, 1'b0,
                         lastr == 15, (lastr == 15) && (v.base == 4'd13), fu ? "R7" : "R6");
            end
        end
    endtask

    task automatic drive(input vec_t v);
        in_list = v.list; in_base = v.base; in_ascend = v.asc; in_pre = v.pre;
        in_user = v.user; in_wb = v.wb; in_load = v.ld;
    endtask

    task automatic compare(input int i, input int vi);
        string w;
        w = $sformatf("vec %0d uop %0d op/dst/src", vi, i);
        chk(out_op == e_op[i] && out_dst == e_dst[i] && out_src == e_src[i], e_tag[i], w,
            {out_op, out_dst, out_src}, {e_op[i], e_dst[i], e_src[i]});
        chk(out_off == e_off[i] && out_ascend == e_asc[i], "R4",
            $sformatf("vec %0d uop %0d off/asc", vi, i), {out_off, out_ascend}, {e_off[i], e_asc[i]});
        chk(out_last == (i == e_n - 1) && out_delay == (i != e_n - 1), "R10",
            $sformatf("vec %0d uop %0d last/delay", vi, i), {out_last, out_delay},
            {(i == e_n - 1), (i != e_n - 1)});
        chk(out_ctrl == e_ctrl[i] && out_ret == e_ret[i], "R9",
            $sformatf("vec %0d uop %0d ctrl/ret", vi, i), {out_ctrl, out_ret}, {e_ctrl[i], e_ret[i]});
    endtask

    task automatic run_vec(input vec_t v, input int vi);
        int got;
        int guard;
        build(v);
        chk(e_n == int'(v.cnt), "R2", $sformatf("vec %0d model count", vi), e_n, v.cnt);
        @(negedge clk);
        drive(v);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        got = 0;
        guard = 0;
        while (out_valid && guard < 100) begin
            out_ready = (cyc % 3) != 2;
            if (out_ready) begin
                if (got < e_n) compare(got, vi);
                got++;
            end
            @(negedge clk);
            guard++;
        end
        out_ready = 1'b0;
        chk(got == int'(v.cnt), "R2", $sformatf("vec %0d emitted count", vi), got, v.cnt);
        chk(in_ready == 1'b1 && busy == 1'b0, "R1", $sformatf("vec %0d idle after", vi),
            {in_ready, busy}, 2'b10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [2:0] h_op;
        logic [5:0] h_dst;
        logic [7:0] h_off;
        int got;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk(out_valid == 1'b0, "R12", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1 && busy == 1'b0, "R12", "in_ready/busy after reset", {in_ready, busy}, 2'b10);

        for (int vi = 0; vi < NV; vi++) begin
            run_vec(VECS[vi], vi);
        end

        // R1 / R11: stalled consumer and an ignored request while busy
        @(negedge clk);
        in_list = 16'h0003; in_base = 4'd9; in_ascend = 1'b1; in_pre = 1'b1;
        in_user = 1'b0; in_wb = 1'b0; in_load = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0 && busy == 1'b1, "R1", "busy after accept", {in_ready, busy}, 2'b01);
        in_list = 16'hFFFF; in_base = 4'd2;
        h_op = out_op; h_dst = out_dst; h_off = out_off;
        chk(out_op == K_ADDI && out_dst == T0 && out_src == 6'd9, "R3", "copy of base 9",
            {out_op, out_dst, out_src}, {K_ADDI, T0, 6'd9});
        repeat (3) @(negedge clk);
        chk(out_valid && out_op == h_op && out_dst == h_dst && out_off == h_off, "R11",
            "held while stalled", {out_op, out_dst, out_off}, {h_op, h_dst, h_off});
        in_valid = 1'b0;
        got = 0;
        out_ready = 1'b1;
        while (out_valid && got < 50) begin
            if (got == 2)
                chk(out_op == K_ST && out_dst == 6'd1 && out_off == 8'd4, "R5",
                    "second store of stall case", {out_op, out_dst, out_off}, {K_ST, 6'd1, 8'd4});
            got++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(got == 3, "R1", "ignored request did not change sequence", got, 3);
        @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", "ignored request never started",
            {out_valid, in_ready}, 2'b01);

        finish_run();
    end
endmodule